// File: doc/BRIEF.md
# Page Access Tracker with Migration Trigger

This block sits beside one bank of a distributed shared L2 cache. It watches every request that reaches the bank from a private L1 cache and records, for each recently touched physical page, how often each cluster of cores has used the page. It also records which cores have touched the page and how many accesses have arrived since the last new core joined. From this history it decides, one cycle after each request, whether the page should be moved closer to its users.

When a move is wanted, the block reports one of two kinds:

- **Solo** means one cluster clearly dominates the page.
- **Sharer** means several cores use the page in roughly equal measure and the set of users has been stable for a while.

The block also reports the sharer vector, so that later logic can pick a destination bank. Two run-time thresholds tune how readily moves happen:

- `gap_thresh` applies to the lead of the busiest cluster over the next busiest.
- `quiet_thresh` applies to the number of accesses since a sharer was last added.

The history table is set-associative and uses true LRU replacement. A page not in the table takes a free way if one exists, and otherwise takes the least recently used way.

A two-state controller sequences the output:

- `ST_IDLE` moves to `ST_RESP` when `req_valid` is high.
- `ST_RESP` stays in `ST_RESP` on a back-to-back request.
- `ST_RESP` returns to `ST_IDLE` when no request is present.

The decision outputs are meaningful only in `ST_RESP`.

Top module: `page_track`

## Requirements
- R1: After reset `dec_valid` is 0. `dec_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 after a cycle without a request. The decision outputs are registered.
- R2: A request with `req_home_local` = 1 updates the history but always yields `dec_migrate` = 0.
- R3: Sharer-mode move is reported as `dec_migrate` = 1 and `dec_sharer_mode` = 1. It fires when all three of these hold, using values that include the current access:
  - the page has more than one sharer;
  - max count minus second-max count is below `gap_thresh`;
  - accesses since the last sharer joined exceed `quiet_thresh`.
- R4: Solo-mode move is reported as `dec_migrate` = 1 and `dec_sharer_mode` = 0. It fires when the requester's cluster is the max cluster and either the sharer count is exactly 1 or the gap is at least `gap_thresh`.
- R5: Each page keeps one 6-bit saturating counter per cluster. The cluster of a core is `core >> 1`, so cores 2k and 2k+1 share a counter. A counter at 63 stays at 63.
- R6: The max count, second-max count and max cluster are updated incrementally on each access:
  - If the incremented cluster already holds the max, the max follows it.
  - Otherwise, a value strictly above the max takes over the max and pushes the old max to second.
  - Otherwise, a value strictly above the second becomes the second.
  - A tie therefore leaves the max cluster unchanged and the gap at 0.
- R7: `dec_sharers` bit c is 1 when core c has touched the page while it has been resident. Setting a new bit resets the since-last-sharer count to 0. A repeat access by a known sharer adds 1 to that count, saturating at 63.
- R8: A page that misses allocates the first invalid way of its set, or else the least recently used way. The new entry's counters start at 0, then this access is counted: its cluster count is 1 and only its sharer bit is set. A freshly allocated entry yields `dec_migrate` = 0.
- R9: The set index is the low `SET_W` bits of `req_page` (4 by default). The tag is the remaining upper bits. Pages with different tags in one set are tracked independently.
- R10: `dec_sharer_mode` is 1 only together with `dec_migrate`. A sharer-mode decision always reports at least two sharer bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_page | input | PAGE_W (20) | Physical page number of the request |
| req_core | input | $clog2(CORES) (3) | Requesting core |
| req_home_local | input | 1 | Page's current home bank is local to the requester |
| gap_thresh | input | CNT_W (6) | Threshold on max minus second-max count |
| quiet_thresh | input | CNT_W (6) | Threshold on accesses since last sharer joined |
| dec_valid | output | 1 | Decision outputs valid |
| dec_migrate | output | 1 | Page should migrate |
| dec_sharer_mode | output | 1 | 1 = sharer mode, 0 = solo mode |
| dec_sharers | output | CORES (8) | Sharer vector after this access |

## Verification
Most internal faults in this block surface only after a delay, and only through `dec_migrate` and `dec_sharer_mode`:

- A counter that wraps instead of saturating does not show at the ports until a second cluster starts using the page and the gap is compared against a threshold.
- A wrong replacement choice shows one or two requests later, when a page that should still be resident is treated as new and its migration is suppressed.
- A wrong tie rule in the max tracking shows as a solo decision going to the wrong cluster.

The stimulus therefore runs long access chains on single pages, steps thresholds across exact boundaries, and revisits evicted and retained pages immediately after a replacement.

// File: rtl/page_track_pkg.sv
package page_track_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } track_state_e;
endpackage

// File: rtl/page_track_wsel.sv
// Way selection: hit way, else first invalid way, else LRU (oldest age).
module page_track_wsel #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0]             way_hit,
    input  logic [WAYS-1:0][AGE_W-1:0]  way_age,
    output logic                        any_hit,
    output logic [AGE_W-1:0]            sel_way
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic [AGE_W-1:0] hit_way, free_way, lru_way;
    logic             have_free;

    always_comb begin
        hit_way   = '0;
        free_way  = '0;
        lru_way   = '0;
        have_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w])             hit_way  = AGE_W'(w);
            if (!way_valid[w]) begin
                free_way  = AGE_W'(w);
                have_free = 1'b1;
            end
            if (way_age[w] == OLDEST)   lru_way  = AGE_W'(w);
        end
        any_hit = |way_hit;
        if (any_hit)        sel_way = hit_way;
        else if (have_free) sel_way = free_way;
        else                sel_way = lru_way;
    end
endmodule

// File: rtl/page_track_lru.sv
// True LRU ages: touched way becomes 0, younger ways age by one.
module page_track_lru #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic [AGE_W-1:0]           touch_way,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);
    logic [AGE_W-1:0] touched_age;
    assign touched_age = age_in[touch_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (AGE_W'(w) == touch_way)
                age_out[w] = '0;
            else if (age_in[w] < touched_age)
                age_out[w] = age_in[w] + AGE_W'(1);
            else
                age_out[w] = age_in[w];
        end
    end
endmodule

// File: rtl/page_track_upd.sv
// Next-state of one tracked page after counting the current access.
module page_track_upd #(
    parameter int CORES    = 8,
    parameter int CLUSTERS = 4,
    parameter int CNT_W    = 6,
    parameter int CORE_W   = 3,
    parameter int CL_W     = 2,
    parameter int POP_W    = 4
) (
    input  logic                            fresh,
    input  logic [CORE_W-1:0]               core,
    input  logic [CL_W-1:0]                 cluster,
    input  logic [CLUSTERS-1:0][CNT_W-1:0]  cnt_in,
    input  logic [CNT_W-1:0]                top_in,
    input  logic [CNT_W-1:0]                runner_in,
    input  logic [CL_W-1:0]                 top_cl_in,
    input  logic [CORES-1:0]                shr_in,
    input  logic [POP_W-1:0]                pop_in,
    input  logic [CNT_W-1:0]                quiet_in,
    output logic [CLUSTERS-1:0][CNT_W-1:0]  cnt_out,
    output logic [CNT_W-1:0]                top_out,
    output logic [CNT_W-1:0]                runner_out,
    output logic [CL_W-1:0]                 top_cl_out,
    output logic [CORES-1:0]                shr_out,
    output logic [POP_W-1:0]                pop_out,
    output logic [CNT_W-1:0]                quiet_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CLUSTERS-1:0][CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] base_top, base_runner, base_quiet, old_v, new_v;
    logic [CL_W-1:0]  base_top_cl;
    logic [CORES-1:0] base_shr;
    logic [POP_W-1:0] base_pop;
    logic             joined;

    always_comb begin
        if (fresh) begin
            base_cnt    = '0;
            base_top    = '0;
            base_runner = '0;
            base_top_cl = cluster;
            base_shr    = '0;
            base_pop    = '0;
            base_quiet  = '0;
        end else begin
            base_cnt    = cnt_in;
            base_top    = top_in;
            base_runner = runner_in;
            base_top_cl = top_cl_in;
            base_shr    = shr_in;
            base_pop    = pop_in;
            base_quiet  = quiet_in;
        end

        old_v = base_cnt[cluster];
        new_v = (old_v == CNT_MAX) ? old_v : old_v + CNT_W'(1);
        cnt_out          = base_cnt;
        cnt_out[cluster] = new_v;

        top_out    = base_top;
        runner_out = base_runner;
        top_cl_out = base_top_cl;
        if (cluster == base_top_cl) begin
            top_out = new_v;
        end else if (new_v > base_top) begin
            runner_out = base_top;
            top_out    = new_v;
            top_cl_out = cluster;
        end else if (new_v > base_runner) begin
            runner_out = new_v;
        end

        joined  = !base_shr[core];
        shr_out = base_shr;
        shr_out[core] = 1'b1;
        pop_out = base_pop + {{(POP_W-1){1'b0}}, joined};
        if (joined)
            quiet_out = '0;
        else
            quiet_out = (base_quiet == CNT_MAX) ? base_quiet : base_quiet + CNT_W'(1);
    end
endmodule

// File: rtl/page_track_rule.sv
// Migration rules applied to the updated page state.
module page_track_rule #(
    parameter int CNT_W = 6,
    parameter int CL_W  = 2,
    parameter int POP_W = 4
) (
    input  logic              fresh,
    input  logic              home_local,
    input  logic [CL_W-1:0]   cluster,
    input  logic [CNT_W-1:0]  top,
    input  logic [CNT_W-1:0]  runner,
    input  logic [CL_W-1:0]   top_cl,
    input  logic [POP_W-1:0]  pop,
    input  logic [CNT_W-1:0]  quiet,
    input  logic [CNT_W-1:0]  gap_thresh,
    input  logic [CNT_W-1:0]  quiet_thresh,
    output logic              migrate,
    output logic              sharer_mode
);
    localparam logic [POP_W-1:0] ONE = POP_W'(1);

    logic [CNT_W-1:0] gap;
    logic             blocked, shared_ok, solo_ok;

    always_comb begin
        gap       = top - runner;
        blocked   = fresh || home_local;
        shared_ok = (pop > ONE) && (gap < gap_thresh) && (quiet > quiet_thresh);
        solo_ok   = ((pop == ONE) || (gap >= gap_thresh)) && (cluster == top_cl);
        migrate     = !blocked && (shared_ok || solo_ok);
        sharer_mode = !blocked && shared_ok;
    end
endmodule

// File: rtl/page_track.sv
module page_track
    import page_track_pkg::*;
#(
    parameter int PAGE_W    = 20,
    parameter int CORES     = 8,
    parameter int CL_SIZE   = 2,
    parameter int CNT_W     = 6,
    parameter int SETS      = 16,
    parameter int WAYS      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [PAGE_W-1:0]          req_page,
    input  logic [$clog2(CORES)-1:0]   req_core,
    input  logic                       req_home_local,
    input  logic [CNT_W-1:0]           gap_thresh,
    input  logic [CNT_W-1:0]           quiet_thresh,
    output logic                       dec_valid,
    output logic                       dec_migrate,
    output logic                       dec_sharer_mode,
    output logic [CORES-1:0]           dec_sharers
);
    localparam int CLUSTERS = CORES / CL_SIZE;
    localparam int CORE_W   = $clog2(CORES);
    localparam int CL_W     = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1;
    localparam int CSZ_W    = $clog2(CL_SIZE);
    localparam int SET_W    = $clog2(SETS);
    localparam int TAG_W    = PAGE_W - SET_W;
    localparam int AGE_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int POP_W    = $clog2(CORES + 1);

    // Table storage
    logic [WAYS-1:0]                         valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]              tag_q   [SETS];
    logic [WAYS-1:0][AGE_W-1:0]              age_q   [SETS];
    logic [CLUSTERS-1:0][CNT_W-1:0]          cnt_q   [SETS][WAYS];
    logic [CNT_W-1:0]                        top_q   [SETS][WAYS];
    logic [CNT_W-1:0]                        run_q   [SETS][WAYS];
    logic [CL_W-1:0]                         topcl_q [SETS][WAYS];
    logic [CORES-1:0]                        shr_q   [SETS][WAYS];
    logic [POP_W-1:0]                        pop_q   [SETS][WAYS];
    logic [CNT_W-1:0]                        quiet_q [SETS][WAYS];

    // Request decode
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [CORE_W-1:0] cl_wide;
    logic [CL_W-1:0]   req_cl;

    assign set_idx = req_page[SET_W-1:0];
    assign req_tag = req_page[PAGE_W-1:SET_W];
    assign cl_wide = req_core >> CSZ_W;
    assign req_cl  = cl_wide[CL_W-1:0];

    // Lookup
    logic [WAYS-1:0]             way_hit;
    logic [WAYS-1:0]             set_valid;
    logic [WAYS-1:0][AGE_W-1:0]  set_age;
    logic                        any_hit;
    logic [AGE_W-1:0]            sel_way;

    assign set_valid = valid_q[set_idx];
    assign set_age   = age_q[set_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = set_valid[w] && (tag_q[set_idx][w] == req_tag);
    end

    page_track_wsel #(.WAYS(WAYS), .AGE_W(AGE_W)) u_wsel (
        .way_valid (set_valid),
        .way_hit   (way_hit),
        .way_age   (set_age),
        .any_hit   (any_hit),
        .sel_way   (sel_way)
    );

    logic [WAYS-1:0][AGE_W-1:0] age_nx;

    page_track_lru #(.WAYS(WAYS), .AGE_W(AGE_W)) u_lru (
        .age_in    (set_age),
        .touch_way (sel_way),
        .age_out   (age_nx)
    );

    // Entry update
    logic [CLUSTERS-1:0][CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] top_nx, run_nx, quiet_nx;
    logic [CL_W-1:0]  topcl_nx;
    logic [CORES-1:0] shr_nx;
    logic [POP_W-1:0] pop_nx;
    logic             fresh;

    assign fresh = !any_hit;

    page_track_upd #(
        .CORES(CORES), .CLUSTERS(CLUSTERS), .CNT_W(CNT_W),
        .CORE_W(CORE_W), .CL_W(CL_W), .POP_W(POP_W)
    ) u_upd (
        .fresh      (fresh),
        .core       (req_core),
        .cluster    (req_cl),
        .cnt_in     (cnt_q[set_idx][sel_way]),
        .top_in     (top_q[set_idx][sel_way]),
        .runner_in  (run_q[set_idx][sel_way]),
        .top_cl_in  (topcl_q[set_idx][sel_way]),
        .shr_in     (shr_q[set_idx][sel_way]),
        .pop_in     (pop_q[set_idx][sel_way]),
        .quiet_in   (quiet_q[set_idx][sel_way]),
        .cnt_out    (cnt_nx),
        .top_out    (top_nx),
        .runner_out (run_nx),
        .top_cl_out (topcl_nx),
        .shr_out    (shr_nx),
        .pop_out    (pop_nx),
        .quiet_out  (quiet_nx)
    );

    logic mig_nx, mode_nx;

    page_track_rule #(.CNT_W(CNT_W), .CL_W(CL_W), .POP_W(POP_W)) u_rule (
        .fresh        (fresh),
        .home_local   (req_home_local),
        .cluster      (req_cl),
        .top          (top_nx),
        .runner       (run_nx),
        .top_cl       (topcl_nx),
        .pop          (pop_nx),
        .quiet        (quiet_nx),
        .gap_thresh   (gap_thresh),
        .quiet_thresh (quiet_thresh),
        .migrate      (mig_nx),
        .sharer_mode  (mode_nx)
    );

    // Table write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    age_q[s][w]   <= AGE_W'(w);
                    cnt_q[s][w]   <= '0;
                    top_q[s][w]   <= '0;
                    run_q[s][w]   <= '0;
                    topcl_q[s][w] <= '0;
                    shr_q[s][w]   <= '0;
                    pop_q[s][w]   <= '0;
                    quiet_q[s][w] <= '0;
                end
            end
        end else if (req_valid) begin
            valid_q[set_idx][sel_way]   <= 1'b1;
            tag_q[set_idx][sel_way]     <= req_tag;
            age_q[set_idx]              <= age_nx;
            cnt_q[set_idx][sel_way]     <= cnt_nx;
            top_q[set_idx][sel_way]     <= top_nx;
            run_q[set_idx][sel_way]     <= run_nx;
            topcl_q[set_idx][sel_way]   <= topcl_nx;
            shr_q[set_idx][sel_way]     <= shr_nx;
            pop_q[set_idx][sel_way]     <= pop_nx;
            quiet_q[set_idx][sel_way]   <= quiet_nx;
        end
    end

    // Controller: state register
    track_state_e state_q;
    logic         mig_q, mode_q;
    logic [CORES-1:0] shr_out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mig_q     <= 1'b0;
            mode_q    <= 1'b0;
            shr_out_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= req_valid ? ST_RESP : ST_IDLE;
                ST_RESP: state_q <= req_valid ? ST_RESP : ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
            if (req_valid) begin
                mig_q     <= mig_nx;
                mode_q    <= mode_nx;
                shr_out_q <= shr_nx;
            end
        end
    end

    // Controller: outputs
    always_comb begin
        unique case (state_q)
            ST_RESP: begin
                dec_valid       = 1'b1;
                dec_migrate     = mig_q;
                dec_sharer_mode = mode_q;
                dec_sharers     = shr_out_q;
            end
            default: begin
                dec_valid       = 1'b0;
                dec_migrate     = 1'b0;
                dec_sharer_mode = 1'b0;
                dec_sharers     = '0;
            end
        endcase
    end
endmodule

// File: rtl/page_track_chk.sv
module page_track_chk #(
    parameter int CORES = 8,
    parameter int CORE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [CORE_W-1:0] req_core,
    input logic              req_home_local,
    input logic              dec_valid,
    input logic              dec_migrate,
    input logic              dec_sharer_mode,
    input logic [CORES-1:0]  dec_sharers
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid); // R1

    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid); // R1

    AST_LOCAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_home_local) |=> !dec_migrate); // R2

    AST_MODE_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sharer_mode |-> dec_migrate); // R10

    AST_SHARED_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_migrate && dec_sharer_mode) |-> ($countones(dec_sharers) > 1)); // R3

    AST_REQ_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (((dec_sharers >> $past(req_core)) & CORES'(1)) != '0)); // R7
endmodule

bind page_track page_track_chk #(.CORES(CORES), .CORE_W($clog2(CORES))) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_core        (req_core),
    .req_home_local  (req_home_local),
    .dec_valid       (dec_valid),
    .dec_migrate     (dec_migrate),
    .dec_sharer_mode (dec_sharer_mode),
    .dec_sharers     (dec_sharers)
);

// File: tb/page_track_test.sv
module page_track_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_page = '0;
    logic [2:0]  req_core = '0;
    logic        req_home_local = 1'b0;
    logic [5:0]  gap_thresh = 6'd4;
    logic [5:0]  quiet_thresh = 6'd2;
    logic        dec_valid, dec_migrate, dec_sharer_mode;
    logic [7:0]  dec_sharers;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    page_track uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
        .req_core(req_core), .req_home_local(req_home_local),
        .gap_thresh(gap_thresh), .quiet_thresh(quiet_thresh),
        .dec_valid(dec_valid), .dec_migrate(dec_migrate),
        .dec_sharer_mode(dec_sharer_mode), .dec_sharers(dec_sharers)
    );

    // {page, core, local, gap_t, quiet_t, exp_mig, exp_mode, exp_shr}
    localparam int NV = 15;
    localparam logic [45:0] VECS [NV] = '{
        {20'h00010, 3'd0, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h01}, // R8 fresh
        {20'h00010, 3'd0, 1'b0, 6'd4, 6'd2, 1'b1, 1'b0, 8'h01}, // R4 solo single sharer
        {20'h00010, 3'd1, 1'b1, 6'd4, 6'd2, 1'b0, 1'b0, 8'h03}, // R2 local
        {20'h00010, 3'd2, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h07}, // R7 join
        {20'h00010, 3'd2, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h07}, // R6
        {20'h00010, 3'd2, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h07}, // R3 quiet == T2
        {20'h00010, 3'd3, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h0F}, // R6 takeover
        {20'h00010, 3'd3, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h0F},
        {20'h00010, 3'd3, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h0F},
        {20'h00010, 3'd3, 1'b0, 6'd8, 6'd2, 1'b1, 1'b1, 8'h0F}, // R3 sharer
        {20'h00010, 3'd3, 1'b0, 6'd4, 6'd2, 1'b1, 1'b0, 8'h0F}, // R4 gap >= T1
        {20'h00010, 3'd0, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h0F}, // R4 not max cluster
        {20'h00010, 3'd0, 1'b1, 6'd8, 6'd2, 1'b0, 1'b0, 8'h0F}, // R2 blocks sharer
        {20'h00021, 3'd7, 1'b0, 6'd4, 6'd2, 1'b0, 1'b0, 8'h80}, // R9 other set
        {20'h00021, 3'd7, 1'b0, 6'd4, 6'd2, 1'b1, 1'b0, 8'h80}  // R5 cluster 3
    };

    task automatic send(input logic [19:0] pg, input logic [2:0] c, input logic loc,
                        input logic [5:0] tg, input logic [5:0] tq);
        @(negedge clk);
        req_page = pg; req_core = c; req_home_local = loc;
        gap_thresh = tg; quiet_thresh = tq; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check(input string req, input logic em, input logic emd,
                         input logic [7:0] es);
        n_checks++;
        if (dec_valid !== 1'b1 || dec_migrate !== em || dec_sharer_mode !== emd
            || dec_sharers !== es) begin
            n_fail++;
            $display("FAIL %s: got v=%b mig=%b mode=%b shr=%h, expected v=1 mig=%b mode=%b shr=%h",
                     req, dec_valid, dec_migrate, dec_sharer_mode, dec_sharers, em, emd, es);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_checks++;
        if (dec_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: dec_valid=%b expected 0", dec_valid);
        end
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            send(VECS[i][45:26], VECS[i][25:23], VECS[i][22], VECS[i][21:16], VECS[i][15:10]);
            check($sformatf("vector %0d (R2-R9 table)", i), VECS[i][9], VECS[i][8], VECS[i][7:0]);
        end

        // R1: no request -> no valid
        @(negedge clk);
        n_checks++;
        if (dec_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle: dec_valid=%b expected 0", dec_valid);
        end

        // R8 eviction: fill set 2 with four tags, fifth evicts the oldest
        for (int t = 1; t <= 5; t++) begin
            send(20'((t << 4) | 2), 3'd0, 1'b0, 6'd4, 6'd2);
            check("R8 allocate", 1'b0, 1'b0, 8'h01);
        end
        send(20'h00042, 3'd0, 1'b0, 6'd4, 6'd2);
        check("R8 retained page hits", 1'b1, 1'b0, 8'h01);
        send(20'h00012, 3'd0, 1'b0, 6'd4, 6'd2);
        check("R8 evicted page re-allocated", 1'b0, 1'b0, 8'h01);

        // R5 saturation: 70 accesses from core 4 to one page
        for (int k = 0; k < 70; k++)
            send(20'h00013, 3'd4, 1'b0, 6'd4, 6'd2);
        check("R5 long solo run", 1'b1, 1'b0, 8'h10);
        send(20'h00013, 3'd6, 1'b0, 6'd10, 6'd0);
        check("R7 new sharer resets quiet", 1'b0, 1'b0, 8'h50);
        send(20'h00013, 3'd6, 1'b0, 6'd10, 6'd0);
        check("R5 saturated gap 61 >= 10", 1'b0, 1'b0, 8'h50);
        send(20'h00013, 3'd6, 1'b0, 6'd62, 6'd0);
        check("R3 gap 60 < 62", 1'b1, 1'b1, 8'h50);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule